// File: doc/BRIEF.md
# Prioritized Interrupt Condition Register

The block collects four processor interrupt conditions: an operator console request, a paging error, a paging queue condition and a supervisor call. Each condition has a pending flag. The flag is set by a strobe, or by the rising edge of the console key, and it stays set until the interrupt is accepted. When several flags are pending, an arbiter picks the one with the lowest priority number. The chosen interrupt is loaded into an output grant register. That register carries the priority number and a code that tells the sequencing logic how the current instruction must end: run it to completion, terminate it with undefined results, or suppress it so it can be re-executed later.

The grant leaves the block on a valid/ready stream. Once `take_valid` rises, `take_code` and `take_end` stay frozen until `take_ready` is seen high on a clock edge. That edge is the handshake. It clears the accepted flag and drops `take_valid` for at least one cycle before the next grant can load. The consumer may hold `take_ready` low for as long as it likes, and no flag is lost in the meantime. The interrupt status word shows the pending flags, and its low byte holds the register field of the last supervisor call that was executed.

Top module: `intr_cond_reg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `take_valid` is 0 and `stat` is all zeros.
- R2: A strobe on `perr_stb`, `pq_stb` or `svc_stb` sets the flag for that condition on the next edge. The flags show in `stat` at bit 17 (console), bit 18 (paging error), bit 19 (paging queue) and bit 20 (supervisor call).
- R3: The priority numbers are 18 (console), 19 (paging error), 20 (paging queue) and 21 (supervisor call), and `take_code` carries this number. When several eligible flags are pending, the lowest number is granted. A grant loads on the edge after its flag becomes visible, provided `take_valid` is low.
- R4: A pending console flag is eligible for a grant only in a cycle where `insn_done` is 1. The other three conditions are eligible regardless of `insn_done`.
- R5: `take_end` encodes how the instruction ends: 0 = complete (console and supervisor call), 1 = terminate (paging error), 2 = suppress (paging queue).
- R6: `svc_stb` loads `svc_field` into `stat[7:0]` on the next edge. The byte is held until the next `svc_stb`.
- R7: A flag clears only on the handshake edge of its own grant. If a new strobe for the same condition arrives on that edge, the flag stays set.
- R8: While `take_valid` is 1 and `take_ready` is 0, `take_valid`, `take_code` and `take_end` hold their values. After a handshake, `take_valid` is 0 for at least one cycle.
- R9: With `int_en` at 0, no new grant loads, but flags still set. A grant that is already presented stays until it is accepted.
- R10: `key_raw` passes through a two-stage synchronizer and a rising-edge detector. Its flag sets on the third edge after the key rises, and a key held high sets the flag only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_raw | input | 1 | Asynchronous console key level |
| perr_stb | input | 1 | Paging error strobe from the translation checker |
| pq_stb | input | 1 | Paging queue strobe from the translation checker |
| svc_stb | input | 1 | Supervisor call executed strobe |
| svc_field | input | 8 | Register field of the supervisor call |
| insn_done | input | 1 | Current instruction is at its completion boundary |
| int_en | input | 1 | Global enable for loading new grants |
| take_ready | input | 1 | Consumer accepts the presented grant |
| take_valid | output | 1 | A grant is presented |
| take_code | output | 5 | Priority number of the granted condition |
| take_end | output | 2 | Instruction ending kind for the grant |
| stat | output | 32 | Interrupt status word: flags and supervisor call byte |

## Verification
The bench builds the block with its default parameters: four conditions, a two-stage key synchronizer, flags starting at bit 17 and priority numbers starting at 18. With these values the exact flag positions and codes can be checked, along with the three-edge delay of the console key. A long key hold can then be watched after its single flag has been granted and cleared. Simultaneous strobes, a console flag waiting on `insn_done`, a presented grant held against back-pressure, and a strobe arriving on the very edge its flag clears are all within reach of the cycle model.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_COND = 4;
  localparam int IDX_CONSOLE = 0;
  localparam int IDX_PERR = 1;
  localparam int IDX_PQ = 2;
  localparam int IDX_SVC = 3;

  typedef enum logic [1:0] {
    END_COMPLETE  = 2'd0,
    END_TERMINATE = 2'd1,
    END_SUPPRESS  = 2'd2
  } end_kind_e;

  function automatic end_kind_e end_kind_of(input int idx);
    case (idx)
      IDX_PERR: return END_TERMINATE;
      IDX_PQ:   return END_SUPPRESS;
      default:  return END_COMPLETE;
    endcase
  endfunction
endpackage

// File: rtl/key_sync_edge.sv
module key_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_async,
  output logic key_rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], key_async};
  end

  assign key_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_rise |=> !key_rise);
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
  parameter int N = 4,
  parameter int SVC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic             svc_stb,
  input  logic [SVC_W-1:0] svc_field,
  output logic [N-1:0]     flags_o,
  output logic [SVC_W-1:0] svc_byte_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set_i[i] | (f_q & ~clr_i[i]);
    end
    assign flags_o[i] = f_q;

    // R7
    clr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |-> f_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       svc_byte_o <= '0;
    else if (svc_stb) svc_byte_o <= svc_field;
  end

  // R6
  svc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |=> svc_byte_o == $past(svc_field));
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
  parameter int N = 4,
  parameter int GATED_IDX = 0,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     flags_i,
  input  logic             boundary_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] elig;

  always_comb begin
    elig = flags_i;
    elig[GATED_IDX] = flags_i[GATED_IDX] & boundary_i;
    found_o = |elig;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intr_cond_reg.sv
module intr_cond_reg
  import intr_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int FLAG_LSB = 17,
  parameter int BASE_PRIO = 18,
  parameter int CODE_W = 5,
  parameter int SVC_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_raw,
  input  logic              perr_stb,
  input  logic              pq_stb,
  input  logic              svc_stb,
  input  logic [SVC_W-1:0]  svc_field,
  input  logic              insn_done,
  input  logic              int_en,
  input  logic              take_ready,
  output logic              take_valid,
  output logic [CODE_W-1:0] take_code,
  output logic [1:0]        take_end,
  output logic [STAT_W-1:0] stat
);
  localparam int N = NUM_COND;
  localparam int IDX_W = $clog2(N);

  logic             key_rise;
  logic [N-1:0]     set_v, clr_v, flags;
  logic [SVC_W-1:0] svc_byte;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] held_idx;
  logic             handshake;

  key_sync_edge #(.STAGES(SYNC_STAGES)) i_key (
    .clk(clk), .rst_n(rst_n), .key_async(key_raw), .key_rise(key_rise)
  );

  always_comb begin
    set_v = '0;
    set_v[IDX_CONSOLE] = key_rise;
    set_v[IDX_PERR] = perr_stb;
    set_v[IDX_PQ] = pq_stb;
    set_v[IDX_SVC] = svc_stb;
  end

  assign handshake = take_valid & take_ready;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr_v[i] = handshake && (held_idx == IDX_W'(i));
  end

  intr_flag_bank #(.N(N), .SVC_W(SVC_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
    .svc_stb(svc_stb), .svc_field(svc_field),
    .flags_o(flags), .svc_byte_o(svc_byte)
  );

  intr_arbiter #(.N(N), .GATED_IDX(IDX_CONSOLE)) i_arb (
    .flags_i(flags), .boundary_i(insn_done), .found_o(found), .idx_o(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      held_idx   <= '0;
      take_code  <= '0;
      take_end   <= END_COMPLETE;
    end else if (handshake) begin
      take_valid <= 1'b0;
    end else if (!take_valid && int_en && found) begin
      take_valid <= 1'b1;
      held_idx   <= win_idx;
      take_code  <= CODE_W'(BASE_PRIO) + CODE_W'(win_idx);
      take_end   <= end_kind_of(int'(win_idx));
    end
  end

  always_comb begin
    stat = '0;
    stat[SVC_W-1:0] = svc_byte;
    stat[FLAG_LSB +: N] = flags;
  end

  // R8
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !take_ready |=> take_valid && $stable(take_code) && $stable(take_end));

  // R8
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ready |=> !take_valid);

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !$past(take_valid) |-> $past(int_en));

  // R4
  console_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !$past(take_valid) && take_code == CODE_W'(BASE_PRIO) |-> $past(insn_done));
endmodule

// File: tb/test_intr_cond_reg.sv
module test_intr_cond_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_raw = 0, perr_stb = 0, pq_stb = 0, svc_stb = 0;
  logic [7:0] svc_field = 8'h00;
  logic insn_done = 0, int_en = 0, take_ready = 0;
  logic take_valid;
  logic [4:0] take_code;
  logic [1:0] take_end;
  logic [31:0] stat;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_cond_reg i_intr_cond_reg (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .perr_stb(perr_stb),
    .pq_stb(pq_stb), .svc_stb(svc_stb), .svc_field(svc_field),
    .insn_done(insn_done), .int_en(int_en), .take_ready(take_ready),
    .take_valid(take_valid), .take_code(take_code), .take_end(take_end),
    .stat(stat)
  );

  // Behavioural reference: key history kept as a queue, flags as a bit array.
  bit key_hist[$];
  bit m_flag[4];
  int m_byte;
  bit m_valid;
  int m_code, m_end;

  always @(posedge clk) begin
    if (!rst_n) begin
      key_hist = {0, 0, 0};
      foreach (m_flag[i]) m_flag[i] = 0;
      m_byte = 0; m_valid = 0; m_code = 0; m_end = 0;
    end else begin
      bit rise, hs;
      int pick, accepted;
      rise = key_hist[1] && !key_hist[2];
      hs = m_valid && take_ready;
      accepted = hs ? m_code - 18 : -1;
      pick = -1;
      for (int i = 3; i >= 0; i--)
        if (m_flag[i] && (i != 0 || insn_done)) pick = i;
      if (hs) m_valid = 0;
      else if (!m_valid && int_en && pick >= 0) begin
        m_valid = 1;
        m_code = 18 + pick;
        m_end = (pick == 1) ? 1 : (pick == 2) ? 2 : 0;
      end
      for (int i = 0; i < 4; i++) if (accepted == i) m_flag[i] = 0;
      if (rise) m_flag[0] = 1;
      if (perr_stb) m_flag[1] = 1;
      if (pq_stb) m_flag[2] = 1;
      if (svc_stb) begin m_flag[3] = 1; m_byte = svc_field; end
      key_hist.push_front(key_raw);
      void'(key_hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 valid", 32'(take_valid), 32'(m_valid));
      if (m_valid) begin
        chk("R3 code", 32'(take_code), 32'(m_code));
        chk("R5 end", 32'(take_end), 32'(m_end));
      end
      chk("R6 byte", 32'(stat[7:0]), 32'(m_byte));
      chk("R2 flags", 32'(stat[20:17]),
          32'({m_flag[3], m_flag[2], m_flag[1], m_flag[0]}));
      chk("R2 unused", 32'({stat[31:21], stat[16:8]}), 32'd0);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin : run
        step(3);
        chk("R1 valid", 32'(take_valid), 0);
        chk("R1 stat", stat, 0);
        rst_n = 1;
        step(1);
        chk("R1 after", {31'd0, take_valid} | stat, 0);

        // R9: flags set while disabled, no grant
        perr_stb = 1; pq_stb = 1; step(1); perr_stb = 0; pq_stb = 0;
        step(4);
        chk("R9 novalid", 32'(take_valid), 0);
        chk("R9 flags", 32'(stat[19:18]), 32'h3);

        // R3/R5: perr (19) before pq (20); R8 hold under back-pressure
        int_en = 1; step(4);
        chk("R3 first", 32'(take_code), 19);
        chk("R5 terminate", 32'(take_end), 1);
        take_ready = 1; step(1); take_ready = 0;
        chk("R8 gap", 32'(take_valid), 0);
        step(1);
        chk("R3 second", 32'(take_code), 20);
        chk("R5 suppress", 32'(take_end), 2);
        take_ready = 1; step(3); take_ready = 0;

        // R6 and R7: svc strobe again on the accepting edge keeps flag
        svc_field = 8'hA5; svc_stb = 1; step(1); svc_stb = 0;
        step(2);
        chk("R6 byte", 32'(stat[7:0]), 32'hA5);
        chk("R3 svc", 32'(take_code), 21);
        svc_field = 8'h3C; svc_stb = 1; take_ready = 1; step(1);
        svc_stb = 0; take_ready = 0;
        chk("R7 reset", 32'(stat[20]), 1);
        step(2);
        chk("R6 new", 32'(stat[7:0]), 32'h3C);
        take_ready = 1; step(2); take_ready = 0; step(2);

        // R10 and R4: key held long, console waits for insn_done
        insn_done = 0; key_raw = 1; step(2);
        chk("R10 early", 32'(stat[17]), 0);
        step(1);
        chk("R10 set", 32'(stat[17]), 1);
        step(6);
        chk("R4 wait", 32'(take_valid), 0);
        insn_done = 1; step(1); insn_done = 0;
        chk("R4 code", 32'(take_code), 18);
        chk("R5 complete", 32'(take_end), 0);
        take_ready = 1; step(1); take_ready = 0;
        step(10);
        chk("R10 once", 32'(stat[17]), 0);
        key_raw = 0;

        // Simultaneous strobes with console pending and random traffic
        for (int k = 0; k < 400; k++) begin
          key_raw = ($urandom % 7) == 0;
          perr_stb = ($urandom % 5) == 0;
          pq_stb = ($urandom % 5) == 0;
          svc_stb = ($urandom % 6) == 0;
          svc_field = 8'($urandom);
          insn_done = $urandom % 2;
          int_en = ($urandom % 4) != 0;
          take_ready = $urandom % 2;
          step(1);
        end
        done = 1;
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule